// File: doc/BRIEF.md
# Masked-Write GPIO Port

A 32-pin general-purpose I/O port sitting on a small 32-bit register bus. The bus has an address, write data, a write strobe, a read strobe and read data. Every pin has its own direction bit and its own stored output value. The pad ring takes one output-enable signal and one output-data signal per pin. Incoming pin levels go through a two-flop synchroniser. They can then be read back as one 32-bit word.

Direction never changes through a read-modify-write. One register turns pins into outputs when their bits are written as 1. A second register turns pins into inputs the same way. Output values are written one half-word at a time. The upper half of each write word is a per-bit mask. So software can change a single pin with one store, and no other pin is disturbed. An output value can be loaded while its pin is still an input. The pin then starts at that level the moment it is switched to output.

Top module: `pio_mask_port`

## Requirements
- R1: A write to offset 0x00 makes every pin whose data bit is 1 an output and leaves every other direction bit unchanged. A read of offset 0x00 returns zero.
- R2: A write to offset 0x04 makes every pin whose data bit is 1 an input and leaves every other direction bit unchanged. A read of offset 0x04 returns the direction of all pins, bit n for pin n, with 1 meaning output.
- R3: Offset 0x08 holds the output values of pins 0 to 15 and offset 0x0C holds those of pins 16 to 31. A write to one half never changes the other half. A read returns that half's values in bits 15:0, with bits 31:16 zero.
- R4: In a write to 0x08 or 0x0C, bit 16+k is the mask for bit k. A pin whose mask bit is 1 takes data bit k. A pin whose mask bit is 0 keeps its value, so a write with an all-zero mask changes nothing.
- R5: A read of offset 0x10 returns the synchronised level of all 32 pins. A level applied before clock edge k is returned by a read whose strobe is sampled at edge k+2 or later. A read sampled at edge k+1 still returns the previous level.
- R6: An output value written while its pin is an input is stored. The pin drives that value in the same cycle that its output enable rises.
- R7: After reset every pin is an input, and every stored output value is 0.
- R8: A read of any offset other than 0x04, 0x08, 0x0C or 0x10 returns zero, including misaligned addresses. A write to any offset other than 0x00, 0x04, 0x08 or 0x0C changes no state.
- R9: Output enable n equals direction bit n, and output data n equals stored value n, at every moment.
- R10: Read data is registered. It updates on the clock edge at which the read strobe is high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| pin_do | output | 32 | Per-pin output value |

## Verification
The direction registers are tested with overlapping set and clear patterns.
- A clear that names only some of the already-set pins shows whether the unnamed pins are left alone.
- A set with scattered bits shows whether bits written as 0 leave their pins unchanged.

The output halves are tested with four kinds of write:
- A full mask.
- A single-bit mask that clears one pin.
- An all-zero mask.
- A write to the upper half only.

Together these tell a correct mask apart from one that is ignored, inverted or applied to the wrong half.

Pin input is changed and then read at two successive cycles, which exposes a synchroniser with too few or too many stages. Offsets that are unused, write-only or misaligned are probed to show that they read as zero and leave the pins untouched.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned PIO_DATA_W = 32;
  localparam int unsigned PIO_HALF_W = PIO_DATA_W / 2;
  localparam int unsigned PIO_HALVES = 2;

  // register offsets (byte addresses)
  localparam int unsigned OFF_DIR_SET = 'h00;
  localparam int unsigned OFF_DIR_CLR = 'h04;
  localparam int unsigned OFF_OUT_LO  = 'h08;
  localparam int unsigned OFF_OUT_HI  = 'h0C;
  localparam int unsigned OFF_PIN_IN  = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_DIR_SET = 3'd1,
    SEL_DIR_CLR = 3'd2,
    SEL_OUT_LO  = 3'd3,
    SEL_OUT_HI  = 3'd4,
    SEL_PIN_IN  = 3'd5
  } pio_sel_e;

  // new half-word value: masked bits take the data, the rest keep the old value
  function automatic logic [PIO_HALF_W-1:0] half_merge(
    input logic [PIO_HALF_W-1:0] cur,
    input logic [PIO_DATA_W-1:0] word
  );
    logic [PIO_HALF_W-1:0] msk;
    msk = word[PIO_DATA_W-1:PIO_HALF_W];
    return (cur & ~msk) | (word[PIO_HALF_W-1:0] & msk);
  endfunction

  // direction update for a set write and a clear write
  function automatic logic [PIO_DATA_W-1:0] dir_next(
    input logic [PIO_DATA_W-1:0] cur,
    input logic [PIO_DATA_W-1:0] word,
    input logic                  set_en,
    input logic                  clr_en
  );
    logic [PIO_DATA_W-1:0] v;
    v = cur;
    if (set_en) v = v | word;
    if (clr_en) v = v & ~word;
    return v;
  endfunction

endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output pio_sel_e          sel,
  output logic              wr_dir_set,
  output logic              wr_dir_clr,
  output logic [PIO_HALVES-1:0] wr_out,
  output logic              wr_hit,
  output logic              rd_hit
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_DIR_SET)) sel = SEL_DIR_SET;
    else if (addr == ADDR_W'(OFF_DIR_CLR)) sel = SEL_DIR_CLR;
    else if (addr == ADDR_W'(OFF_OUT_LO))  sel = SEL_OUT_LO;
    else if (addr == ADDR_W'(OFF_OUT_HI))  sel = SEL_OUT_HI;
    else if (addr == ADDR_W'(OFF_PIN_IN))  sel = SEL_PIN_IN;
  end

  assign wr_dir_set = wr && (sel == SEL_DIR_SET);
  assign wr_dir_clr = wr && (sel == SEL_DIR_CLR);
  assign wr_out[0]  = wr && (sel == SEL_OUT_LO);
  assign wr_out[1]  = wr && (sel == SEL_OUT_HI);
  assign wr_hit     = (sel == SEL_DIR_SET) || (sel == SEL_DIR_CLR) ||
                      (sel == SEL_OUT_LO)  || (sel == SEL_OUT_HI);
  assign rd_hit     = rd && (sel != SEL_NONE) && (sel != SEL_DIR_SET);

endmodule

// File: rtl/pio_dir_reg.sv
module pio_dir_reg
  import pio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic                  clr_en,
  input  logic [PIO_DATA_W-1:0] wdata,
  output logic [PIO_DATA_W-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (set_en || clr_en) dir_q <= dir_next(dir_q, wdata, set_en, clr_en);
  end

endmodule

// File: rtl/pio_out_half.sv
module pio_out_half
  import pio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PIO_DATA_W-1:0] wdata,
  output logic [PIO_HALF_W-1:0] val_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else if (wr_en) val_q <= half_merge(val_q, wdata);
  end

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync
  import pio_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIO_DATA_W-1:0] raw,
  output logic [PIO_DATA_W-1:0] synced
);

  logic [PIO_DATA_W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= raw;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/pio_mask_port.sv
module pio_mask_port
  import pio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_oe,
  output logic [31:0]       pin_do
);

  pio_sel_e              sel;
  logic                  wr_dir_set;
  logic                  wr_dir_clr;
  logic [PIO_HALVES-1:0] wr_out;
  logic                  wr_hit;
  logic                  rd_hit;
  logic [PIO_DATA_W-1:0] dir_q;
  logic [PIO_DATA_W-1:0] pin_sync;
  logic [PIO_HALF_W-1:0] out_half [PIO_HALVES];
  logic [PIO_DATA_W-1:0] rd_mux;

  pio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(sel),
    .wr_dir_set(wr_dir_set), .wr_dir_clr(wr_dir_clr), .wr_out(wr_out),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  pio_dir_reg u_dir (
    .clk(clk), .rst_n(rst_n), .set_en(wr_dir_set), .clr_en(wr_dir_clr),
    .wdata(bus_wdata), .dir_q(dir_q)
  );

  generate
    for (genvar h = 0; h < PIO_HALVES; h++) begin : g_half
      pio_out_half u_out (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_out[h]), .wdata(bus_wdata),
        .val_q(out_half[h])
      );
      assign pin_do[h*PIO_HALF_W +: PIO_HALF_W] = out_half[h];
    end
  endgenerate

  pio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(pin_sync)
  );

  assign pin_oe = dir_q;

  always_comb begin
    rd_mux = '0;
    if (rd_hit) begin
      case (sel)
        SEL_DIR_CLR: rd_mux = dir_q;
        SEL_OUT_LO:  rd_mux = {{PIO_HALF_W{1'b0}}, out_half[0]};
        SEL_OUT_HI:  rd_mux = {{PIO_HALF_W{1'b0}}, out_half[1]};
        SEL_PIN_IN:  rd_mux = pin_sync;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/pio_mask_port_chk.sv
module pio_mask_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        wr_hit,
  input logic        wr_dir_set,
  input logic        wr_dir_clr,
  input logic [1:0]  wr_out,
  input logic [31:0] pin_oe,
  input logic [31:0] pin_do,
  input logic        rd_hit
);

  assert_dir_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_set |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

  assert_dir_set_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_set |=> (((pin_oe ^ $past(pin_oe)) & ~$past(bus_wdata)) == 32'h0));

  assert_dir_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_clr |=> ((pin_oe & $past(bus_wdata)) == 32'h0));

  assert_half_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out[0] |=> $stable(pin_do[31:16]) && $stable(pin_oe));

  assert_mask_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out[0] |=> (((pin_do[15:0] ^ $past(pin_do[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

  assert_mask_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out[1] |=> (((pin_do[31:16] ^ $past(pin_do[31:16])) & ~$past(bus_wdata[31:16])) == 16'h0)
                  && $stable(pin_do[15:0]));

  assert_undef_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_hit) |=> $stable(pin_oe) && $stable(pin_do));

  assert_undef_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> (bus_rdata == 32'h0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R7: assert (pin_oe == 32'h0 && pin_do == 32'h0);
    end
  end

endmodule

bind pio_mask_port pio_mask_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .wr_hit(wr_hit),
  .wr_dir_set(wr_dir_set), .wr_dir_clr(wr_dir_clr), .wr_out(wr_out),
  .pin_oe(pin_oe), .pin_do(pin_do), .rd_hit(rd_hit)
);

// File: tb/pio_mask_port_tb.sv
module pio_mask_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe;
  logic [31:0] pin_do;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R7 oe after reset", pin_oe, 32'h0);
    check("R7 do after reset", pin_do, 32'h0);
    bus_read(8'h04, d);
    check("R7 dir read after reset", d, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] d;
    bus_write(8'h00, 32'h0000_00F0);
    check("R1 set 0xF0", pin_oe, 32'h0000_00F0);
    bus_write(8'h00, 32'h8000_0F00);
    check("R1 set keeps others", pin_oe, 32'h8000_0FF0);
    bus_write(8'h04, 32'h0000_0030);
    check("R2 clear subset", pin_oe, 32'h8000_0FC0);
    bus_read(8'h04, d);
    check("R2 dir readback", d, 32'h8000_0FC0);
    bus_read(8'h00, d);
    check("R1 set reg reads zero", d, 32'h0);
    check("R9 oe tracks dir", pin_oe, d | 32'h8000_0FC0);
    bus_write(8'h04, 32'hFFFF_FFFF);
    check("R2 clear all", pin_oe, 32'h0);
  endtask

  task automatic t_out_mask();
    logic [31:0] d;
    bus_write(8'h08, 32'hFFFF_A5A5);
    check("R4 full mask lo", pin_do, 32'h0000_A5A5);
    bus_write(8'h08, 32'h0001_0000);
    check("R4 single-bit clear", pin_do, 32'h0000_A5A4);
    bus_write(8'h08, 32'h0000_FFFF);
    check("R4 zero mask no change", pin_do, 32'h0000_A5A4);
    bus_write(8'h0C, 32'h8000_8000);
    check("R3 hi half only", pin_do, 32'h8000_A5A4);
    bus_read(8'h08, d);
    check("R3 lo readback", d, 32'h0000_A5A4);
    bus_read(8'h0C, d);
    check("R3 hi readback", d, 32'h0000_8000);
  endtask

  task automatic t_preload();
    bus_write(8'h08, 32'h0008_0008);
    check("R6 stored while input oe", pin_oe, 32'h0);
    check("R6 stored value", pin_do[3], 1'b1);
    bus_write(8'h00, 32'h0000_0008);
    check("R6 oe rises", pin_oe, 32'h0000_0008);
    check("R6 drives preload", {31'h0, pin_do[3]}, 32'h1);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 8'h10; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R5 read at k+1 old", bus_rdata, 32'h0);
    bus_read(8'h10, d);
    check("R5 read at k+2 new", d, 32'h1234_5678);
  endtask

  task automatic t_undef();
    logic [31:0] oe0, do0, d;
    oe0 = pin_oe; do0 = pin_do;
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(8'h09, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'hFFFF_FFFF);
    check("R8 undef write oe", pin_oe, oe0);
    check("R8 undef write do", pin_do, do0);
    bus_read(8'h14, d);
    check("R8 undef read", d, 32'h0);
    bus_read(8'h0E, d);
    check("R8 misaligned read", d, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    bus_read(8'h04, d);
    check("R10 read value", d, 32'h0000_0008);
    bus_write(8'h00, 32'h00FF_0000);
    repeat (3) @(negedge clk);
    check("R10 rdata held", bus_rdata, 32'h0000_0008);
    check("R9 do unchanged by dir", pin_do, 32'h8000_A5AC);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_out_mask();
    t_preload();
    t_sync();
    t_undef();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule